// File: doc/BRIEF.md
# Serial Transfer Interrupt Timing Generator

This block decides when a byte-serial port raises its transfer-complete interrupt. It counts synchronized serial-clock rising edges from a transfer-start strobe. Depending on a small set of mode and control bits, it fires a one-cycle interrupt request at one of three points: after the eighth edge (the data byte), after the ninth edge (the acknowledge slot), or, in wake-up mode, when a stop condition arrives after a received byte that matched the slave address.

During the acknowledge slot of a receive it can also ask the pin logic to drive the acknowledge bit. Control-bit combinations outside the allowed table raise an illegal-setting flag, and no interrupt is generated while that flag is high. The bus pin drivers and the shift register are outside this block; the shift register's byte and the slave address arrive as inputs.

Top module: `sio_irq_timer`

## Requirements
- R1: With `bus_i2c`=0 and `busy_en`, `wake_en`, `wait_hi`, `wait_lo`, `ack_en` all 0, `irq` is high for exactly the one cycle after the cycle in which the 8th `sclk_rise` since `xfer_start` is seen.
- R2: Transmit (`bus_i2c`=1, `busy_en`=0, `wake_en`=0, `ack_en`=0): wait bits {`wait_hi`,`wait_lo`}=10 fire `irq` after the 8th edge, and 11 fire it after the 9th edge.
- R3: Receive (`bus_i2c`=1, `busy_en`=1, `wake_en`=0): wait bits 10 with `ack_en`=0 fire after the 8th edge; wait bits 11 fire after the 9th edge with `ack_en` either 0 or 1.
- R4: `ack_drive` is high from the cycle after the 8th edge until the cycle after the 9th edge, only when `ack_en`=1 in a 9-clock receive or in wake-up mode; otherwise it stays low.
- R5: Wake-up mode (all six bits 1): `rx_byte` is compared with `slave_addr` in the cycle of the 8th edge; a later `stop_det` with a match gives `irq` in the following cycle, and the edges themselves never do.
- R6: In wake-up mode a stop condition without a latched match gives no `irq`.
- R7: Any other combination of the six bits drives `cfg_illegal` high in the same cycle and produces no `irq`.
- R8: `irq` is never high two cycles in a row, and at most one pulse occurs per transfer; further edges after the interrupt have no effect.
- R9: `xfer_start` resets the edge count to zero, so a restarted transfer interrupts on the 8th or 9th edge after the restart.
- R10: After reset `irq` and `ack_drive` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_rise | input | 1 | One-cycle strobe per synchronized serial clock rising edge |
| xfer_start | input | 1 | One-cycle strobe marking the start of a byte transfer |
| stop_det | input | 1 | One-cycle strobe for a detected stop condition |
| bus_i2c | input | 1 | 0: 3-wire/2-wire mode, 1: two-wire addressed bus mode |
| busy_en | input | 1 | Busy enable (1 in receive) |
| wake_en | input | 1 | Wake-up (address match) mode |
| wait_hi | input | 1 | Upper wait bit |
| wait_lo | input | 1 | Lower wait bit |
| ack_en | input | 1 | Automatic acknowledge enable |
| rx_byte | input | 8 | Current shift-register byte |
| slave_addr | input | 8 | Own slave address |
| irq | output | 1 | One-cycle interrupt request |
| ack_drive | output | 1 | Request to drive the acknowledge bit |
| cfg_illegal | output | 1 | Prohibited control combination |

## Verification
The assertions assume that `xfer_start`, `sclk_rise` and `stop_det` are single-cycle strobes that never coincide, and that the control bits are held steady for the whole of a transfer. The bench changes the configuration only between transfers, just before a start strobe, and separates every strobe by idle cycles. It also places each stop strobe after all serial edges of the byte. The sweep over all 64 bit combinations keeps to these rules too, so that the flag and interrupt checks see each combination cleanly.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

  typedef enum logic [1:0] {
    PT_NONE = 2'd0,
    PT_BYTE = 2'd1,
    PT_ACK  = 2'd2,
    PT_ADDR = 2'd3
  } irq_point_e;

  // Legal-setting table; PT_NONE marks a prohibited combination.
  function automatic irq_point_e decode_point(input logic i2c, input logic busy,
                                              input logic wake, input logic whi,
                                              input logic wlo, input logic ack);
    irq_point_e pt;
    pt = PT_NONE;
    if (!i2c) begin
      if (!busy && !wake && !whi && !wlo && !ack) pt = PT_BYTE;
    end else if (!busy) begin
      if (!wake && whi && !ack) pt = wlo ? PT_ACK : PT_BYTE;
    end else if (!wake) begin
      if (whi && !wlo && !ack) pt = PT_BYTE;
      else if (whi && wlo) pt = PT_ACK;
    end else begin
      if (whi && wlo && ack) pt = PT_ADDR;
    end
    return pt;
  endfunction

  function automatic logic wants_auto_ack(input irq_point_e pt, input logic ack);
    return ack && (pt == PT_ACK || pt == PT_ADDR);
  endfunction

endpackage

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode
  import sio_irq_pkg::*;
(
  input  logic       bus_i2c,
  input  logic       busy_en,
  input  logic       wake_en,
  input  logic       wait_hi,
  input  logic       wait_lo,
  input  logic       ack_en,
  output irq_point_e point,
  output logic       illegal,
  output logic       auto_ack
);
  always_comb begin
    point    = decode_point(bus_i2c, busy_en, wake_en, wait_hi, wait_lo, ack_en);
    illegal  = (point == PT_NONE);
    auto_ack = wants_auto_ack(point, ack_en);
  end
endmodule

// File: rtl/sio_edge_counter.sv
module sio_edge_counter #(
  parameter int BYTE_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic edge_stb,
  input  logic freeze,
  output logic [$clog2(BYTE_BITS+2)-1:0] count,
  output logic reach_byte,
  output logic reach_ack
);
  localparam int CNT_W    = $clog2(BYTE_BITS + 2);
  localparam int ACK_SLOT = BYTE_BITS + 1;

  logic [CNT_W-1:0] cnt_q;
  logic             hold;
  logic             step;

  assign hold       = freeze || (cnt_q == CNT_W'(ACK_SLOT));
  assign step       = edge_stb && !start && !hold;
  assign reach_byte = step && (cnt_q == CNT_W'(BYTE_BITS - 1));
  assign reach_ack  = step && (cnt_q == CNT_W'(BYTE_BITS));
  assign count      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (start) cnt_q <= '0;
    else if (step)  cnt_q <= cnt_q + 1'b1;
  end

  assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (count == '0));

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(ACK_SLOT));
endmodule

// File: rtl/sio_addr_match.sv
module sio_addr_match #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              latch,
  input  logic [ADDR_W-1:0] rx_byte,
  input  logic [ADDR_W-1:0] slave_addr,
  output logic              hit
);
  logic hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hit_q <= 1'b0;
    else if (clear) hit_q <= 1'b0;
    else if (latch) hit_q <= (rx_byte == slave_addr);
  end

  assign hit = hit_q;

  assert_hit_needs_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit) |-> $past(latch));
endmodule

// File: rtl/sio_irq_timer.sv
module sio_irq_timer
  import sio_irq_pkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk_rise,
  input  logic                 xfer_start,
  input  logic                 stop_det,
  input  logic                 bus_i2c,
  input  logic                 busy_en,
  input  logic                 wake_en,
  input  logic                 wait_hi,
  input  logic                 wait_lo,
  input  logic                 ack_en,
  input  logic [BYTE_BITS-1:0] rx_byte,
  input  logic [BYTE_BITS-1:0] slave_addr,
  output logic                 irq,
  output logic                 ack_drive,
  output logic                 cfg_illegal
);
  localparam int CNT_W = $clog2(BYTE_BITS + 2);

  irq_point_e       point;
  logic             illegal;
  logic             auto_ack;
  logic [CNT_W-1:0] count;
  logic             reach_byte;
  logic             reach_ack;
  logic             match_hit;
  logic             done_q;
  logic             irq_q;
  logic             fire_byte;
  logic             fire_ack;
  logic             fire_addr;
  logic             fire;

  sio_cfg_decode u_dec (
    .bus_i2c (bus_i2c),
    .busy_en (busy_en),
    .wake_en (wake_en),
    .wait_hi (wait_hi),
    .wait_lo (wait_lo),
    .ack_en  (ack_en),
    .point   (point),
    .illegal (illegal),
    .auto_ack(auto_ack)
  );

  sio_edge_counter #(.BYTE_BITS(BYTE_BITS)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (xfer_start),
    .edge_stb  (sclk_rise),
    .freeze    (done_q),
    .count     (count),
    .reach_byte(reach_byte),
    .reach_ack (reach_ack)
  );

  sio_addr_match #(.ADDR_W(BYTE_BITS)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (xfer_start || fire_addr),
    .latch     (reach_byte),
    .rx_byte   (rx_byte),
    .slave_addr(slave_addr),
    .hit       (match_hit)
  );

  // Named qualifying events, one per interrupt point.
  assign fire_byte = (point == PT_BYTE) && reach_byte;
  assign fire_ack  = (point == PT_ACK)  && reach_ack;
  assign fire_addr = (point == PT_ADDR) && stop_det && match_hit && !done_q && !xfer_start;
  assign fire      = !illegal && (fire_byte || fire_ack || fire_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= fire;
      if (xfer_start) done_q <= 1'b0;
      else if (fire)  done_q <= 1'b1;
    end
  end

  assign irq         = irq_q;
  assign cfg_illegal = illegal;
  assign ack_drive   = auto_ack && !illegal && !done_q && (count == CNT_W'(BYTE_BITS));

  assert_one_cycle_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_illegal_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_illegal |=> !irq);

  assert_ack_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_drive |-> (ack_en && !cfg_illegal));

  assert_addr_irq_on_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(point == PT_ADDR)) |-> $past(stop_det));
endmodule

// File: tb/sim_sio_irq_timer.sv
module sim_sio_irq_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk_rise = 1'b0, xfer_start = 1'b0, stop_det = 1'b0;
  logic [5:0] cfg = 6'b0;  // {bus_i2c, busy_en, wake_en, wait_hi, wait_lo, ack_en}
  logic [7:0] rx_byte = 8'h00, slave_addr = 8'h5A;
  logic irq, ack_drive, cfg_illegal;

  int n_checks = 0, n_fail = 0;
  string tag = "R10";
  bit finished = 0;

  always #10 clk = ~clk;

  sio_irq_timer u0 (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .xfer_start(xfer_start),
    .stop_det(stop_det), .bus_i2c(cfg[5]), .busy_en(cfg[4]), .wake_en(cfg[3]),
    .wait_hi(cfg[2]), .wait_lo(cfg[1]), .ack_en(cfg[0]), .rx_byte(rx_byte),
    .slave_addr(slave_addr), .irq(irq), .ack_drive(ack_drive), .cfg_illegal(cfg_illegal)
  );

  // Reference: 0 = illegal, 8 / 9 = clock count, 100 = address-match mode.
  function automatic int ref_point(input logic [5:0] c);
    case (c)
      6'b000000, 6'b100100, 6'b110100: return 8;
      6'b100110, 6'b110110, 6'b110111: return 9;
      6'b111111:                       return 100;
      default:                         return 0;
    endcase
  endfunction

  int  m_edges = 0;
  bit  m_done = 0, m_match = 0, m_irq = 0;
  int  irq_seen = 0, irq_expected = 0;

  always @(posedge clk) begin
    int pt;
    bit r8, r9, go;
    pt = ref_point(cfg);
    if (!rst_n) begin
      m_edges = 0; m_done = 0; m_match = 0; m_irq = 0;
    end else if (xfer_start) begin
      m_edges = 0; m_done = 0; m_match = 0; m_irq = 0;
    end else begin
      r8 = sclk_rise && !m_done && m_edges == 7;
      r9 = sclk_rise && !m_done && m_edges == 8;
      go = (pt == 8 && r8) || (pt == 9 && r9) ||
           (pt == 100 && stop_det && m_match && !m_done);
      m_irq = go;
      if (sclk_rise && !m_done && m_edges < 9) m_edges++;
      if (go) begin
        m_done = 1;
        if (pt == 100) m_match = 0;
      end else if (r8) m_match = (rx_byte == slave_addr);
      if (go) irq_expected++;
    end
  end

  task automatic chk(input string what, input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string what, input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (rst_n && !finished) begin
      int pt;
      bit ack_exp;
      pt = ref_point(cfg);
      ack_exp = (pt != 0) && cfg[0] && (pt == 9 || pt == 100) && m_edges == 8 && !m_done;
      chk("irq", tag, irq, m_irq);
      chk("ack_drive", "R4", ack_drive, ack_exp);
      chk("cfg_illegal", "R7", cfg_illegal, pt == 0);
      if (irq) irq_seen++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe_start();
    @(negedge clk) xfer_start = 1'b1;
    @(negedge clk) xfer_start = 1'b0;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sclk_rise = 1'b1;
      @(negedge clk) sclk_rise = 1'b0;
      idle(2);
    end
  endtask

  task automatic strobe_stop();
    @(negedge clk) stop_det = 1'b1;
    @(negedge clk) stop_det = 1'b0;
    idle(2);
  endtask

  // One transfer; checks the number of interrupt pulses it produced.
  task automatic transfer(input logic [5:0] c, input int n_edges, input bit with_stop,
                          input int want_irqs, input string req);
    int base;
    @(negedge clk) cfg = c;
    strobe_start();
    base = irq_seen;
    edges(n_edges);
    if (with_stop) strobe_stop();
    idle(3);
    chk_int("irq pulses per transfer", req, irq_seen - base, want_irqs);
  endtask

  task automatic finish_up();
    finished = 1;
    chk_int("total irq pulses vs reference", "R8", irq_seen, irq_expected);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    idle(3);
    tag = "R10";
    chk("irq in reset", "R10", irq, 1'b0);
    chk("ack_drive in reset", "R10", ack_drive, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    idle(2);
    chk("irq after reset", "R10", irq, 1'b0);
    chk("ack_drive after reset", "R10", ack_drive, 1'b0);

    tag = "R1";  transfer(6'b000000, 12, 0, 1, "R1");
    tag = "R2";  transfer(6'b100100, 9, 0, 1, "R2");
                 transfer(6'b100110, 12, 0, 1, "R2");
    tag = "R3";  transfer(6'b110100, 9, 0, 1, "R3");
                 transfer(6'b110110, 9, 0, 1, "R3");
    tag = "R4";  transfer(6'b110111, 11, 0, 1, "R4");
    tag = "R5";  rx_byte = 8'h5A; transfer(6'b111111, 9, 1, 1, "R5");
                 transfer(6'b111111, 9, 0, 0, "R5");
    tag = "R6";  rx_byte = 8'h5B; transfer(6'b111111, 9, 1, 0, "R6");
                 rx_byte = 8'h5A; transfer(6'b111111, 0, 1, 0, "R6");
    tag = "R9";  @(negedge clk) cfg = 6'b000000;
                 strobe_start(); edges(5);
                 transfer(6'b000000, 8, 0, 1, "R9");
                 transfer(6'b000000, 7, 0, 0, "R9");
    tag = "R7";
    for (int c = 0; c < 64; c++) begin
      int want;
      want = (ref_point(6'(c)) == 0) ? 0 : 1;
      rx_byte = slave_addr;
      transfer(6'(c), 9, 1, want, "R7");
    end
    tag = "R8";  transfer(6'b100110, 15, 1, 1, "R8");
    idle(4);
    finish_up();
  end
endmodule